// File: doc/BRIEF.md
# Parallel EEPROM Write-Cycle Controller

This block is a clocked model of the control logic of a byte-writable nonvolatile memory with 2048 locations of 8 bits. It takes three active-low strobes (chip select, output gate and write strobe), an 11-bit address and a byte of write data. It serves reads from an internal register array, and it turns a valid write-strobe pulse into a self-timed cycle. That cycle first erases the chosen byte to all ones and then programs the new value.

While a cycle runs, the controller pulls an open-drain-style ready line low. It also answers reads of the byte being written with a polling pattern, so that software can see when the cycle has finished. A write is suppressed in any of these cases: the combined strobe pulse is too short, the output gate is active, a cycle is already running, the power-good input is low, or the power-on hold-off has not yet expired.

All times are counted in clock cycles set by parameters, so a simulation can use scaled values. The strobes are taken as synchronous to the clock. The data bus is split into an input, an output and an output-valid flag.

Top module: `eew_ctrl_top`

## Requirements
- R1: While reset is asserted and after it is released, `ready_od` is 1 (released), `dout_en` is 0 and `dout` is 0 until a read or a write is applied.
- R2: When `cs_n`=0, `og_n`=0 and `wstb_n`=1 at a clock edge, `dout_en` is 1 after that edge and `dout` holds the stored byte at `addr`. Under any other strobe combination `dout_en` and `dout` are 0.
- R3: A write pulse is the run of cycles with `cs_n`=0, `wstb_n`=0 and `og_n`=1. The address is captured in the first cycle of the run, which is when the later of the two falling strobes arrives. The data is the `din` value of the last cycle of the run, which is when the earlier of the two rising strobes arrives.
- R4: After the first edge with the pulse ended, `ready_od` is 0 for exactly ERASE_CYC+PROG_CYC cycles. The byte is erased to 8'hFF and then programmed, and it reads back as the new value afterwards.
- R5: While `ready_od` is 0, a read of the byte being written returns {~data[7], 7'b0}. Reads of other addresses return true data.
- R6: A write pulse that ends while a cycle runs is ignored. The array is unchanged, and the running cycle is neither lengthened nor retargeted.
- R7: A pulse of fewer than MIN_PULSE cycles starts no write. A pulse of exactly MIN_PULSE cycles does start one.
- R8: If `og_n` is 0 while `cs_n` and `wstb_n` are both low, or if `og_n` falls before the pulse ends, no write occurs.
- R9: No write starts while `pwr_ok` is 0, or within INIT_CYC cycles after `pwr_ok` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply-good indication |
| cs_n | input | 1 | Chip select, active low |
| og_n | input | 1 | Output gate, active low |
| wstb_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Read data valid (bus driven) |
| ready_od | output | 1 | 0 = line pulled low (busy), 1 = released |

## Verification
A read is applied in one cycle and its byte is due one clock edge later. The driver places the expected byte in a scoreboard queue as it applies the read, and the monitor pops the queue at the following falling edge, where it compares whenever `dout_en` is high. The busy window is checked against a free-running edge count: with the pulse released at count r, the ready line must be low at r+1 and at r+ERASE_CYC+PROG_CYC, and high again one count later. For suppressed writes, the ready line is sampled at r+1 and r+3, and the target byte is then read back.

// File: rtl/eew_pkg.sv
package eew_pkg;
  localparam int EEW_AW = 11;
  localparam int EEW_DW = 8;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_ERASE = 2'd1,
    CYC_PROG  = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/eew_por_gate.sv
module eew_por_gate #(
  parameter int INIT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic wr_ok
);
  localparam int CW = $clog2(INIT_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pwr_ok)
      cnt_d = '0;
    else if (cnt_q != CW'(INIT_CYC))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wr_ok = pwr_ok & (cnt_q == CW'(INIT_CYC));

  // R9: the permission can only rise while power has been good
  a_r9_holdoff_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ok) |-> $past(pwr_ok));
endmodule

// File: rtl/eew_strobe_dec.sv
module eew_strobe_dec #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int MIN_PULSE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wstb_n,
  input  logic          og_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          allow,
  output logic          commit,
  output logic [AW-1:0] cmt_addr,
  output logic [DW-1:0] cmt_data
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          act_q;
  logic [CW-1:0] len_q, len_d;
  logic [AW-1:0] a_q, a_d;
  logic [DW-1:0] d_q, d_d;
  logic          wr_act, pulse_start, pulse_end;

  assign wr_act      = ~cs_n & ~wstb_n & og_n;
  assign pulse_start = wr_act & ~act_q;
  assign pulse_end   = ~wr_act & act_q;

  always_comb begin
    len_d = len_q;
    a_d   = a_q;
    d_d   = d_q;
    if (pulse_start) begin
      len_d = CW'(1);
      a_d   = addr;
    end else if (wr_act && (len_q != CW'(MIN_PULSE))) begin
      len_d = len_q + 1'b1;
    end
    if (wr_act) d_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      len_q <= '0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      act_q <= wr_act;
      len_q <= len_d;
      a_q   <= a_d;
      d_q   <= d_d;
    end
  end

  assign commit   = pulse_end & og_n & (len_q == CW'(MIN_PULSE)) & allow;
  assign cmt_addr = a_q;
  assign cmt_data = d_q;
endmodule

// File: rtl/eew_cycle_fsm.sv
module eew_cycle_fsm
  import eew_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int ERASE_CYC = 8,
  parameter int PROG_CYC  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] cmt_addr,
  input  logic [DW-1:0] cmt_data,
  output logic          busy,
  output logic [AW-1:0] last_addr,
  output logic [DW-1:0] last_data,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [DW-1:0] arr_wdata
);
  localparam int TMAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(TMAX + 1);

  cyc_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] la_q, la_d;
  logic [DW-1:0] ld_q, ld_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    la_d      = la_q;
    ld_d      = ld_q;
    arr_we    = 1'b0;
    arr_waddr = la_q;
    arr_wdata = ld_q;
    case (st_q)
      CYC_IDLE: begin
        if (commit) begin
          st_d  = CYC_ERASE;
          cnt_d = CW'(ERASE_CYC - 1);
          la_d  = cmt_addr;
          ld_d  = cmt_data;
        end
      end
      CYC_ERASE: begin
        if (cnt_q == '0) begin
          arr_we    = 1'b1;
          arr_wdata = '1;
          st_d      = CYC_PROG;
          cnt_d     = CW'(PROG_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      CYC_PROG: begin
        if (cnt_q == '0) begin
          arr_we = 1'b1;
          st_d   = CYC_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CYC_IDLE;
      cnt_q <= '0;
      la_q  <= '0;
      ld_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      la_q  <= la_d;
      ld_q  <= ld_d;
    end
  end

  assign busy      = (st_q != CYC_IDLE);
  assign last_addr = la_q;
  assign last_data = ld_q;

  // R6: target of a running cycle cannot be replaced
  a_r6_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(last_addr) && $stable(last_data)));
  // R4: erase phase hands over to programming
  a_r4_erase_then_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CYC_ERASE && cnt_q == '0) |=> (st_q == CYC_PROG));
endmodule

// File: rtl/eew_ctrl_top.sv
module eew_ctrl_top
  import eew_pkg::*;
#(
  parameter int ADDR_W    = EEW_AW,
  parameter int DATA_W    = EEW_DW,
  parameter int ERASE_CYC = 8,
  parameter int PROG_CYC  = 12,
  parameter int MIN_PULSE = 4,
  parameter int INIT_CYC  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              cs_n,
  input  logic              og_n,
  input  logic              wstb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              ready_od
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]        rst_pipe;
  logic              rst_ni;
  logic              wr_ok, allow, commit, busy, arr_we;
  logic [ADDR_W-1:0] cmt_addr, last_addr, arr_waddr;
  logic [DATA_W-1:0] cmt_data, last_data, arr_wdata;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_sel, poll_hit;
  logic [DATA_W-1:0] rd_byte, dout_d;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  eew_por_gate #(.INIT_CYC(INIT_CYC)) u_por (
    .clk(clk), .rst_n(rst_ni), .pwr_ok(pwr_ok), .wr_ok(wr_ok));

  assign allow = wr_ok & ~busy;

  eew_strobe_dec #(.AW(ADDR_W), .DW(DATA_W), .MIN_PULSE(MIN_PULSE)) u_dec (
    .clk(clk), .rst_n(rst_ni), .cs_n(cs_n), .wstb_n(wstb_n), .og_n(og_n),
    .addr(addr), .din(din), .allow(allow), .commit(commit),
    .cmt_addr(cmt_addr), .cmt_data(cmt_data));

  eew_cycle_fsm #(.AW(ADDR_W), .DW(DATA_W), .ERASE_CYC(ERASE_CYC),
                  .PROG_CYC(PROG_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_ni), .commit(commit), .cmt_addr(cmt_addr),
    .cmt_data(cmt_data), .busy(busy), .last_addr(last_addr),
    .last_data(last_data), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata));

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (arr_we) mem[arr_waddr] <= arr_wdata;
  end

  assign rd_sel   = ~cs_n & ~og_n & wstb_n;
  assign poll_hit = busy & (addr == last_addr);
  assign rd_byte  = poll_hit ? {~last_data[DATA_W-1], {(DATA_W-1){1'b0}}}
                             : mem[addr];
  assign dout_d   = rd_sel ? rd_byte : '0;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= dout_d;
      dout_en <= rd_sel;
    end
  end

  assign ready_od = ~busy;

  // R2: bus is driven only after a read strobe combination
  a_r2_read_gate: assert property (@(posedge clk) disable iff (!rst_ni)
    dout_en |-> $past(!cs_n && !og_n && wstb_n));
  // R4: a busy period begins only from an accepted pulse
  a_r4_busy_source: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(commit));
  // R6: no acceptance during a running cycle
  a_r6_idle_accept: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |-> !busy);
  // R8: output gate active blocks acceptance
  a_r8_og_lockout: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |-> og_n);
  // R9: acceptance requires good power
  a_r9_power_gate: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |-> pwr_ok);
endmodule

// File: tb/sim_eew_ctrl_top.sv
`timescale 1ns/1ps
module sim_eew_ctrl_top;
  localparam int TBUSY = 8 + 12;

  logic        clk = 1'b0;
  logic        rst_n, pwr_ok, cs_n, og_n, wstb_n;
  logic [10:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en, ready_od;

  int nvec  = 0;
  int nfail = 0;
  int ncyc  = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  eew_ctrl_top u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cs_n(cs_n), .og_n(og_n),
    .wstb_n(wstb_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .ready_od(ready_od));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  // monitor: scoreboard compare one edge after each read
  always @(negedge clk) begin
    if (rst_n && dout_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected dout_en", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dout === e, t, dout, e);
      end
    end
  end

  // driver tasks: called at a falling edge
  task automatic rd(input logic [10:0] a, input logic [7:0] e, input string t);
    addr = a; cs_n = 0; og_n = 0; wstb_n = 1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    cs_n = 1; og_n = 1;
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d, input int p, output int r);
    addr = a; din = d; og_n = 1; cs_n = 0; wstb_n = 0;
    repeat (p) @(negedge clk);
    cs_n = 1; wstb_n = 1;
    r = ncyc;
  endtask

  task automatic wait_to(input int n);
    while (ncyc < n) @(negedge clk);
  endtask

  task automatic chk_no_cycle(input int r, input string t);
    wait_to(r + 1);
    chk(ready_od === 1'b1, t, ready_od, 1);
    wait_to(r + 3);
    chk(ready_od === 1'b1, t, ready_od, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    int r;
    rst_n = 0; pwr_ok = 0; cs_n = 1; og_n = 1; wstb_n = 1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ready_od === 1'b1 && dout_en === 1'b0 && dout === 8'h00, "R1 reset state", {ready_od, dout_en}, 2);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(ready_od === 1'b1 && dout_en === 1'b0 && dout === 8'h00, "R1 after release", {ready_od, dout_en}, 2);

    // R9: power low, then inside the hold-off
    wr(11'h005, 8'h99, 6, r);
    chk_no_cycle(r, "R9 power low");
    pwr_ok = 1;
    wr(11'h005, 8'h99, 6, r);
    chk_no_cycle(r, "R9 inside hold-off");
    repeat (30) @(negedge clk);

    // R3/R4: plain write, busy window and read-back
    wr(11'h7FF, 8'h3C, 6, r);
    wait_to(r + 1);
    chk(ready_od === 1'b0, "R4 busy start", ready_od, 0);
    rd(11'h7FF, 8'h80, "R5 poll bit7 clear");
    wait_to(r + TBUSY);
    chk(ready_od === 1'b0, "R4 busy last cycle", ready_od, 0);
    wait_to(r + TBUSY + 1);
    chk(ready_od === 1'b1, "R4 ready again", ready_od, 1);
    rd(11'h7FF, 8'h3C, "R2 R4 read-back");
    @(negedge clk);
    chk(dout_en === 1'b0 && dout === 8'h00, "R2 idle bus", dout, 0);

    // R7 boundary pulse, R5 polling, R6 ignored write while busy
    wr(11'h005, 8'hA5, 4, r);
    wait_to(r + 1);
    chk(ready_od === 1'b0, "R7 exact minimum accepted", ready_od, 0);
    rd(11'h005, 8'h00, "R5 poll bit7 set");
    rd(11'h7FF, 8'h3C, "R5 other address true");
    begin
      int r2;
      wr(11'h7FF, 8'hFF, 5, r2);
    end
    wait_to(r + TBUSY);
    chk(ready_od === 1'b0, "R6 cycle not shortened", ready_od, 0);
    wait_to(r + TBUSY + 1);
    chk(ready_od === 1'b1, "R6 cycle not lengthened", ready_od, 1);
    repeat (3) @(negedge clk);
    chk(ready_od === 1'b1, "R6 no second cycle", ready_od, 1);
    rd(11'h7FF, 8'h3C, "R6 array unchanged");
    rd(11'h005, 8'hA5, "R4 new byte");

    // R3: chip-select driven pulse, address at later fall, data at earlier rise
    og_n = 1; wstb_n = 0; addr = 11'h0AA; din = 8'h11;
    @(negedge clk);
    cs_n = 0; addr = 11'h123;
    @(negedge clk);
    addr = 11'h456; din = 8'h5A;
    repeat (4) @(negedge clk);
    cs_n = 1;
    r = ncyc;
    @(negedge clk);
    din = 8'h77; wstb_n = 1;
    chk(ready_od === 1'b0, "R3 pulse accepted", ready_od, 0);
    rd(11'h123, 8'h80, "R5 poll latched address");
    wait_to(r + TBUSY + 1);
    chk(ready_od === 1'b1, "R4 ready after cs pulse", ready_od, 1);
    rd(11'h123, 8'h5A, "R3 address and data capture");

    // R7: pulse one cycle too short
    wr(11'h005, 8'h00, 3, r);
    chk_no_cycle(r, "R7 short pulse");
    rd(11'h005, 8'hA5, "R7 byte unchanged");

    // R8: output gate low throughout
    og_n = 0; cs_n = 0; wstb_n = 0; addr = 11'h7FF; din = 8'h00;
    repeat (6) @(negedge clk);
    cs_n = 1; wstb_n = 1; og_n = 1;
    r = ncyc;
    chk_no_cycle(r, "R8 gate low");
    // R8: output gate falls before the pulse ends
    og_n = 1; cs_n = 0; wstb_n = 0; addr = 11'h7FF; din = 8'h01;
    repeat (5) @(negedge clk);
    og_n = 0;
    @(negedge clk);
    cs_n = 1; wstb_n = 1; og_n = 1;
    r = ncyc;
    chk_no_cycle(r, "R8 gate fell mid-pulse");
    rd(11'h7FF, 8'h3C, "R8 byte unchanged");

    // R9: power lost after hold-off
    pwr_ok = 0;
    repeat (2) @(negedge clk);
    wr(11'h005, 8'h12, 6, r);
    chk_no_cycle(r, "R9 power dropped");
    rd(11'h005, 8'hA5, "R9 byte unchanged");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule